// File: doc/BRIEF.md
# Multistream Slot Allocation Table Updater

This block keeps the four-row stream allocation table of a multistream transport link. Each row pairs a stream source identifier with the number of timeslots that stream owns. Software fills a pending copy of the table two rows at a time. It then writes an update request. The request either sends an allocation-change trigger first or skips it. The block moves the pending copy into the active copy only at a transport packet-header boundary, so the slot owners never change in the middle of a packet.

A request that brings a new virtual channel onto the link raises a read-only keepout flag at commit. The flag stays high until a fixed number of packet headers has been sent after the commit point. While an update is in flight, the block reports busy and refuses any new writes to the pending table or to the update field. Software programs unused rows to source 0 with a slot count of 0.

Top module: `mst_slot_table`

## Requirements
- R1: After reset, every active row reads source 0 and count 0, the update field reads 0, and busy, trig_send and keepout are 0.
- R2: A pending write with wr_pair=0 loads rows 0 and 1; wr_pair=1 loads rows 2 and 3. The even row is taken from wr_data[E-1:0] and the odd row from wr_data[2E-1:E]. Each row is packed as {source, count}, with the count in the low CNT_W bits. The active table (row r at act_tbl[r*E +: E]) does not change on a pending write.
- R3: Update code 1 requests an update with a trigger and code 2 requests one without a trigger. Writing code 0 or 3 leaves the block idle. While the block is busy, upd_state shows the accepted code.
- R4: After code 1 is accepted, trig_send is high for exactly the next cycle. A header strobe during that pulse cycle does not commit. The commit happens at the first header strobe after the pulse.
- R5: Code 2 never raises trig_send. A header strobe in the same cycle as the code-2 write does not commit. The commit happens at the first header strobe after that cycle.
- R6: At a commit, all four pending rows become active at once, and upd_state and busy both return to 0. The active table never changes in a cycle without a header strobe.
- R7: While busy, writes to the pending table and to the update field are dropped.
- R8: A commit whose request carried upd_add_vc=1 sets keepout. Keepout clears on the 16th header strobe after the commit, and the commit strobe itself is not counted. A commit without the flag does not set keepout.
- R9: A new commit with upd_add_vc=1 while keepout is high restarts the 16-header count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Pending-table write strobe |
| wr_pair | input | 1 | Row pair select: 0 selects rows 0/1, 1 selects rows 2/3 |
| wr_data | input | 2*(ID_W+CNT_W) | Two packed rows; the even row is in the low half |
| upd_wr | input | 1 | Update-field write strobe |
| upd_code | input | 2 | Update code: 1 = with trigger, 2 = without trigger |
| upd_add_vc | input | 1 | The update adds a virtual channel (sampled with upd_wr) |
| hdr_strobe | input | 1 | One cycle per transmitted packet header |
| act_tbl | output | 4*(ID_W+CNT_W) | Active table, row r at [r*E +: E] |
| upd_state | output | 2 | Update field readback; clears itself at commit |
| busy | output | 1 | An update is in progress |
| trig_send | output | 1 | One-cycle allocation-change trigger pulse |
| keepout | output | 1 | Read-only flag held after a channel-adding commit |

## Verification
The trigger and no-trigger paths each get a header strobe in the cycle where committing would be wrong. For the trigger path this is the pulse cycle; for the no-trigger path it is the request cycle. A design that commits one header too early fails on these strobes. Writes during a busy period carry data that differs from the committed data, so a design that leaks those writes shows up in the active table. The keepout window is probed after 15 and after 16 strobes, and once more with a restarting commit partway through the window. A long stretch of random writes, codes and strobes is compared every cycle against a behavioural model to cover the interleavings.

// File: rtl/mst_slot_table.sv
module mst_slot_table #(
  parameter int ID_W      = 4,
  parameter int CNT_W     = 6,
  parameter int KEEP_HDRS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_pair,
  input  logic [2*(ID_W+CNT_W)-1:0]    wr_data,
  input  logic                         upd_wr,
  input  logic [1:0]                   upd_code,
  input  logic                         upd_add_vc,
  input  logic                         hdr_strobe,
  output logic [4*(ID_W+CNT_W)-1:0]    act_tbl,
  output logic [1:0]                   upd_state,
  output logic                         busy,
  output logic                         trig_send,
  output logic                         keepout
);
  localparam int E    = ID_W + CNT_W;
  localparam int ROWS = 4;
  localparam int KC_W = (KEEP_HDRS > 1) ? $clog2(KEEP_HDRS) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_TRIG, PH_WAIT} phase_t;

  phase_t             phase;
  logic [1:0]         code_q;
  logic               add_q;
  logic [KC_W-1:0]    kcnt;
  logic [ROWS*E-1:0]  pend_tbl;
  logic               idle, commit, accept;

  assign idle   = (phase == PH_IDLE);
  assign commit = (phase == PH_WAIT) && hdr_strobe;
  assign accept = idle && upd_wr && (upd_code == 2'd1 || upd_code == 2'd2);

  assign busy      = !idle;
  assign trig_send = (phase == PH_TRIG);
  assign upd_state = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      code_q <= 2'd0;
      add_q  <= 1'b0;
    end else if (accept) begin
      phase  <= (upd_code == 2'd1) ? PH_TRIG : PH_WAIT;
      code_q <= upd_code;
      add_q  <= upd_add_vc;
    end else if (phase == PH_TRIG) begin
      phase  <= PH_WAIT;
    end else if (commit) begin
      phase  <= PH_IDLE;
      code_q <= 2'd0;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_tbl[r*E +: E] <= '0;
      else if (idle && wr_en && wr_pair == 1'(r / 2))
        pend_tbl[r*E +: E] <= wr_data[(r % 2)*E +: E];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        act_tbl[r*E +: E] <= '0;
      else if (commit)
        act_tbl[r*E +: E] <= pend_tbl[r*E +: E];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keepout <= 1'b0;
      kcnt    <= '0;
    end else if (commit && add_q) begin
      keepout <= 1'b1;
      kcnt    <= '0;
    end else if (keepout && hdr_strobe) begin
      if (kcnt == KC_W'(KEEP_HDRS - 1)) keepout <= 1'b0;
      kcnt <= kcnt + 1'b1;
    end
  end

  assert_trig_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_send |=> !trig_send);
  assert_trig_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_send |=> $stable(act_tbl));
  assert_hold_no_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_strobe |=> $stable(act_tbl));
  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(hdr_strobe));
  assert_idle_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> upd_state == 2'd0);
  assert_pend_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pend_tbl));
  assert_keep_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keepout) |-> ($past(hdr_strobe) && $past(busy)));
endmodule

// File: tb/mst_slot_table_test.sv
`timescale 1ns/1ps
module mst_slot_table_test;
  localparam int E = 10;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_pair = 0, upd_wr = 0, upd_add_vc = 0, hdr_strobe = 0;
  logic [2*E-1:0] wr_data = '0;
  logic [1:0] upd_code = 0;
  logic [4*E-1:0] act_tbl;
  logic [1:0] upd_state;
  logic busy, trig_send, keepout;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  mst_slot_table uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair),
    .wr_data(wr_data), .upd_wr(upd_wr), .upd_code(upd_code), .upd_add_vc(upd_add_vc),
    .hdr_strobe(hdr_strobe), .act_tbl(act_tbl), .upd_state(upd_state), .busy(busy),
    .trig_send(trig_send), .keepout(keepout));

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [E-1:0] m_pend[4], m_act[4];
  int m_ph = 0, m_code = 0, m_add = 0, m_left = 0;

  function automatic logic [E-1:0] row(int src, int cnt);
    return {4'(src), 6'(cnt)};
  endfunction

  function automatic logic [4*E-1:0] m_tbl();
    return {m_act[3], m_act[2], m_act[1], m_act[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_pend[i] = '0; m_act[i] = '0; end
      m_ph = 0; m_code = 0; m_add = 0; m_left = 0;
    end else begin
      automatic int ph = m_ph;
      automatic bit cm = (ph == 2) && hdr_strobe;
      if (ph == 0 && wr_en) begin
        m_pend[wr_pair*2]     = wr_data[E-1:0];
        m_pend[wr_pair*2 + 1] = wr_data[2*E-1:E];
      end
      if (ph == 1) m_ph = 2;
      if (ph == 0 && upd_wr && (upd_code == 1 || upd_code == 2)) begin
        m_code = upd_code; m_add = upd_add_vc; m_ph = (upd_code == 1) ? 1 : 2;
      end
      if (cm) begin
        for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
        m_ph = 0; m_code = 0;
        if (m_add) m_left = 16;
        else if (m_left > 0) m_left--;
      end else if (hdr_strobe && m_left > 0) m_left--;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(act_tbl == m_tbl(), cur_req, "model act_tbl", act_tbl, m_tbl());
    chk(upd_state == 2'(m_code), cur_req, "model upd_state", upd_state, m_code);
    chk(busy == (m_ph != 0), cur_req, "model busy", busy, m_ph != 0);
    chk(trig_send == (m_ph == 1), cur_req, "model trig_send", trig_send, m_ph == 1);
    chk(keepout == (m_left > 0), cur_req, "model keepout", keepout, m_left > 0);
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
    wr_en = 0; upd_wr = 0; hdr_strobe = 0; upd_add_vc = 0;
  endtask

  task automatic wpair(bit p, logic [E-1:0] ev, logic [E-1:0] od);
    wr_en = 1; wr_pair = p; wr_data = {od, ev};
  endtask

  task automatic req(int c, bit add);
    upd_wr = 1; upd_code = 2'(c); upd_add_vc = add;
  endtask

  logic [4*E-1:0] exp1, exp2;

  initial begin
    #(200000 * 5);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(act_tbl == '0 && upd_state == 0 && !busy && !trig_send && !keepout,
        "R1", "reset state", act_tbl, 0);

    cur_req = "R2";
    wpair(0, row(1, 3), row(2, 5)); tick();
    wpair(1, row(3, 7), row(0, 0)); tick();
    chk(act_tbl == '0, "R2", "pending write not active", act_tbl, 0);
    exp1 = {row(0, 0), row(3, 7), row(2, 5), row(1, 3)};

    cur_req = "R5";
    req(2, 0); hdr_strobe = 1; tick();
    chk(busy && act_tbl == '0 && !trig_send, "R5", "no commit on request-cycle header", act_tbl, 0);
    chk(upd_state == 2, "R3", "upd_state shows code 2", upd_state, 2);
    tick(); tick();
    chk(!trig_send, "R5", "no trigger for code 2", trig_send, 0);
    hdr_strobe = 1; tick();
    chk(act_tbl == exp1, "R6", "commit copies rows (R2 layout)", act_tbl, exp1);
    chk(!busy && upd_state == 0, "R6", "field self-clears", upd_state, 0);

    cur_req = "R4";
    wpair(0, row(5, 9), row(6, 10)); tick();
    exp2 = {row(0, 0), row(3, 7), row(6, 10), row(5, 9)};
    req(1, 0); tick();
    chk(trig_send == 1, "R4", "trigger pulse after request", trig_send, 1);
    hdr_strobe = 1; tick();
    chk(!trig_send && busy && act_tbl == exp1, "R4", "no commit on pulse-cycle header", act_tbl, exp1);
    tick();
    hdr_strobe = 1; tick();
    chk(act_tbl == exp2 && !busy, "R4", "commit at header after pulse", act_tbl, exp2);

    cur_req = "R3";
    req(3, 1); tick();
    chk(!busy && upd_state == 0, "R3", "code 3 ignored", busy, 0);
    req(0, 0); tick();
    chk(!busy, "R3", "code 0 ignored", busy, 0);
    hdr_strobe = 1; tick();
    chk(act_tbl == exp2 && !keepout, "R3", "no commit when idle", act_tbl, exp2);

    cur_req = "R7";
    req(2, 0); tick();
    wpair(0, row(15, 63), row(15, 63)); req(1, 1); tick();
    chk(upd_state == 2 && !trig_send, "R7", "busy update write dropped", upd_state, 2);
    hdr_strobe = 1; tick();
    chk(act_tbl == exp2 && !keepout, "R7", "busy table write dropped", act_tbl, exp2);

    cur_req = "R8";
    req(2, 0); tick(); hdr_strobe = 1; tick();
    chk(!keepout, "R8", "no keepout without add", keepout, 0);
    req(2, 1); tick(); hdr_strobe = 1; tick();
    chk(keepout, "R8", "keepout set at commit", keepout, 1);
    for (int i = 0; i < 15; i++) begin hdr_strobe = 1; tick(); tick(); end
    chk(keepout, "R8", "keepout after 15 headers", keepout, 1);
    hdr_strobe = 1; tick();
    chk(!keepout, "R8", "keepout cleared on 16th", keepout, 0);

    cur_req = "R9";
    req(2, 1); tick(); hdr_strobe = 1; tick();
    for (int i = 0; i < 10; i++) begin hdr_strobe = 1; tick(); end
    req(2, 1); tick(); hdr_strobe = 1; tick();
    for (int i = 0; i < 15; i++) begin hdr_strobe = 1; tick(); end
    chk(keepout, "R9", "restarted window still open", keepout, 1);
    hdr_strobe = 1; tick();
    chk(!keepout, "R9", "restarted window closes", keepout, 0);

    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 3) == 0; wr_pair = 1'($urandom); wr_data = 20'($urandom);
      upd_wr = ($urandom % 4) == 0; upd_code = 2'($urandom); upd_add_vc = 1'($urandom);
      hdr_strobe = ($urandom % 3) == 0;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule